// File: doc/BRIEF.md
# Multidrop Serial Receiver with Sleep and Wakeup

This block receives asynchronous serial characters from a shared multidrop line. It samples the line on a 16x oversampling tick, confirms each start bit at mid-bit, and assembles one of three frame layouts. Every layout has one start bit, the payload sent least significant bit first, and one stop bit. The layouts are a 10-bit frame with 8 data bits, an 11-bit frame with 8 data bits plus a parity bit, and an 11-bit frame with 9 data bits. A received character is moved into a holding register and raises a ready flag and an interrupt request.

On a bus shared by many nodes, a node can put its receiver to sleep so that it ignores traffic meant for other nodes. While asleep the receiver reports nothing except the idle-line flag. It wakes up without help from software in one of two ways. In idle-line mode it wakes after a long run of idle ones. In address mode it wakes on a frame whose address bit is set. When it wakes in address mode, the waking frame is delivered normally, so software can compare the address against its own. Software can also end sleep itself, or return to sleep to skip the rest of a message.

Top module: `mdrx_rx`

## Requirements
- R1: The line idles high. A start bit is taken only if the majority vote of the three samples around mid-bit is low, so a low pulse shorter than half a bit is discarded. Frame select `fmt` encoding: 0 = 8 data bits (10-bit frame), 1 = 8 data bits plus parity (11-bit frame), 2 = 9 data bits (11-bit frame), 3 = same as 0. Payload bit i is stored in `rx_data[i]`, and `rx_data[8]` reads 0 for encoding 0.
- R2: An accepted frame loads `rx_data` and sets `rdrf` one clock after its stop bit is sampled.
- R3: `rx_addr` is loaded with `rx_data[8]` for encoding 2 and with `rx_data[7]` for encodings 0, 1 and 3.
- R4: A pulse on `rd_strobe` clears `rdrf`. A load in the same cycle takes precedence.
- R5: While `re` is low no new frame is started, so nothing is loaded. A frame already in progress when `re` falls is completed and loaded.
- R6: A low `re` does not itself clear `rdrf` or `rx_irq`.
- R7: `rx_irq` is high exactly when `rdrf` reads high and `rx_ie` is high.
- R8: While asleep (`rwu`=1 and `sync_mode`=0), `rdrf` and `rx_irq` read 0 and frames that do not wake the receiver are not loaded. A flag set before sleep reappears when sleep ends, and `idle` keeps working.
- R9: With `wake_sel`=1, a frame received while asleep whose address bit (R3) is 1 clears `rwu` and is loaded. A frame whose address bit is 0 leaves the receiver asleep.
- R10: With `wake_sel`=0, an unbroken high run of 10 bit times (encoding 0) or 11 bit times (encodings 1 and 2) clears `rwu`, and the following frame is loaded.
- R11: Reset clears `rwu`, `rdrf`, `idle` and `rx_irq`. A pulse on `rwu_set` sets `rwu`, and a pulse on `rwu_clr` clears it (set wins).
- R12: With `sync_mode`=1, `rwu` has no effect: frames are loaded and visible, and hardware never clears `rwu`.
- R13: `idle` sets when the line has stayed high for the idle run length of R10 after at least one frame since the flag last set. It is cleared when the next start bit is confirmed. A long idle after reset with no frame does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling enable, OVS per bit time |
| rxd | input | 1 | Serial line |
| re | input | 1 | Receiver enable |
| rwu_set | input | 1 | Pulse: enter sleep |
| rwu_clr | input | 1 | Pulse: leave sleep |
| wake_sel | input | 1 | 0 = idle-line wakeup, 1 = address wakeup |
| fmt | input | 2 | Frame layout select (R1) |
| sync_mode | input | 1 | Synchronous mode flag, disables sleep |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Data register read, clears ready flag |
| rx_data | output | 9 | Received payload |
| rx_addr | output | 1 | Address bit of the held character |
| rdrf | output | 1 | Receive data ready |
| idle | output | 1 | Idle line seen after traffic |
| rx_irq | output | 1 | Receive interrupt request |
| rwu | output | 1 | Sleep state |

## Verification
The bench builds the receiver with OVS=8 and SYNC_STAGES=3, with the tick held high. A bit then lasts eight clocks and the idle run lasts 80 or 88 clocks. This keeps each idle-threshold test short enough to probe just before and just after the boundary for both run lengths. The extra synchronizer stage shifts every sampling point by one clock and exercises the delay through the generated stage chain. The three-sample vote remains selected, so a two-clock glitch falls entirely before the vote and must be rejected.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;

   localparam int unsigned WORD_W = 9;

   typedef enum logic [1:0] {
      FMT_STD8  = 2'd0,
      FMT_PAR8  = 2'd1,
      FMT_ADDR9 = 2'd2,
      FMT_ALT8  = 2'd3
   } fmt_e;

   typedef enum logic {
      RX_WAIT = 1'b0,
      RX_BUSY = 1'b1
   } rxst_e;

   // payload bits between start and stop
   function automatic logic [3:0] payload_bits(fmt_e f);
      case (f)
         FMT_PAR8, FMT_ADDR9: payload_bits = 4'd9;
         default:             payload_bits = 4'd8;
      endcase
   endfunction

   function automatic logic [3:0] frame_bits(fmt_e f);
      frame_bits = payload_bits(f) + 4'd2;
   endfunction

   // position of the bit that carries the address marker
   function automatic logic [3:0] addr_pos(fmt_e f);
      addr_pos = (f == FMT_ADDR9) ? 4'd8 : 4'd7;
   endfunction

endpackage

// File: rtl/mdrx_sync.sv
module mdrx_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk) begin
      if (!rst_n) ff <= {STAGES{RST_VAL}};
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];

endmodule

// File: rtl/mdrx_frame.sv
module mdrx_frame import mdrx_pkg::*; #(
   parameter int unsigned OVS   = 16,
   parameter bit          VOTE3 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_s,
   input  logic              re,
   input  fmt_e              fmt,
   output logic              start_ok,
   output logic              done,
   output logic [WORD_W-1:0] word,
   output fmt_e              word_fmt
);

   localparam int unsigned CW = $clog2(OVS);
   localparam int unsigned MID = OVS / 2;
   localparam logic [CW-1:0] S_EARLY = CW'(MID - 1);
   localparam logic [CW-1:0] S_MID   = CW'(MID);
   localparam logic [CW-1:0] S_VOTE  = CW'(MID + 1);
   localparam logic [CW-1:0] S_LAST  = CW'(OVS - 1);

   rxst_e             st;
   logic [CW-1:0]     cnt;
   logic [3:0]        bitpos;
   logic [1:0]        hist;
   logic [WORD_W-1:0] shreg;
   logic [3:0]        stop_pos;
   logic              vote;

   assign stop_pos = payload_bits(word_fmt) + 4'd1;

   generate
      if (VOTE3) begin : g_vote3
         assign vote = (hist[1] & hist[0]) | (hist[1] & rx_s) | (hist[0] & rx_s);
      end else begin : g_vote1
         assign vote = hist[0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= RX_WAIT;
         cnt      <= '0;
         bitpos   <= '0;
         hist     <= 2'b11;
         shreg    <= '0;
         word     <= '0;
         word_fmt <= FMT_STD8;
         done     <= 1'b0;
         start_ok <= 1'b0;
      end else begin
         done     <= 1'b0;
         start_ok <= 1'b0;
         if (tick) begin
            case (st)
               RX_WAIT: begin
                  if (re && !rx_s) begin
                     st       <= RX_BUSY;
                     cnt      <= '0;
                     bitpos   <= '0;
                     shreg    <= '0;
                     word_fmt <= fmt;
                  end
               end
               RX_BUSY: begin
                  cnt <= (cnt == S_LAST) ? '0 : cnt + 1'b1;
                  if (cnt == S_LAST) bitpos <= bitpos + 4'd1;
                  if (cnt == S_EARLY) hist[1] <= rx_s;
                  if (cnt == S_MID)   hist[0] <= rx_s;
                  if (cnt == S_VOTE) begin
                     if (bitpos == 4'd0) begin
                        if (vote) st <= RX_WAIT;
                        else      start_ok <= 1'b1;
                     end else if (bitpos == stop_pos) begin
                        st   <= RX_WAIT;
                        done <= 1'b1;
                        word <= shreg;
                     end else begin
                        shreg[bitpos - 4'd1] <= vote;
                     end
                  end
               end
               default: st <= RX_WAIT;
            endcase
         end
      end
   end

endmodule

// File: rtl/mdrx_idle.sv
module mdrx_idle import mdrx_pkg::*; #(
   parameter int unsigned OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rx_s,
   input  fmt_e fmt,
   output logic idle_evt
);

   localparam int unsigned CNTW = $clog2(11 * OVS + 1);

   logic [CNTW-1:0] run;
   logic [CNTW-1:0] thr;

   assign thr = CNTW'(frame_bits(fmt)) * CNTW'(OVS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run      <= '0;
         idle_evt <= 1'b0;
      end else begin
         idle_evt <= 1'b0;
         if (tick) begin
            if (!rx_s) begin
               run <= '0;
            end else if (run < thr) begin
               run <= run + 1'b1;
               if (run == thr - CNTW'(1)) idle_evt <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/mdrx_ctl.sv
module mdrx_ctl import mdrx_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rwu_set,
   input  logic              rwu_clr,
   input  logic              wake_sel,
   input  logic              sync_mode,
   input  logic              rx_ie,
   input  logic              rd_strobe,
   input  logic              done,
   input  logic [WORD_W-1:0] word,
   input  fmt_e              word_fmt,
   input  logic              start_ok,
   input  logic              idle_evt,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_addr,
   output logic              rdrf,
   output logic              idle,
   output logic              rx_irq,
   output logic              rwu
);

   logic rwu_q, rdrf_q, idle_q, armed;
   logic asleep, addr_bit, addr_wake, idle_wake, xfer;

   assign asleep    = rwu_q & ~sync_mode;
   assign addr_bit  = word[addr_pos(word_fmt)];
   assign addr_wake = asleep & wake_sel & done & addr_bit;
   assign idle_wake = asleep & ~wake_sel & idle_evt;
   assign xfer      = done & (~asleep | addr_wake);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rwu_q   <= 1'b0;
         rdrf_q  <= 1'b0;
         idle_q  <= 1'b0;
         armed   <= 1'b0;
         rx_data <= '0;
         rx_addr <= 1'b0;
      end else begin
         if (rwu_set)                              rwu_q <= 1'b1;
         else if (rwu_clr || addr_wake || idle_wake) rwu_q <= 1'b0;

         if (xfer)           rdrf_q <= 1'b1;
         else if (rd_strobe) rdrf_q <= 1'b0;

         if (xfer) begin
            rx_data <= word;
            rx_addr <= addr_bit;
         end

         if (done)          armed <= 1'b1;
         else if (idle_evt) armed <= 1'b0;

         if (start_ok)               idle_q <= 1'b0;
         else if (idle_evt && armed) idle_q <= 1'b1;
      end
   end

   assign rwu    = rwu_q;
   assign rdrf   = rdrf_q & ~asleep;
   assign rx_irq = rdrf & rx_ie;
   assign idle   = idle_q;

endmodule

// File: rtl/mdrx_rx.sv
module mdrx_rx import mdrx_pkg::*; #(
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          VOTE3       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   input  logic              re,
   input  logic              rwu_set,
   input  logic              rwu_clr,
   input  logic              wake_sel,
   input  logic [1:0]        fmt,
   input  logic              sync_mode,
   input  logic              rx_ie,
   input  logic              rd_strobe,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_addr,
   output logic              rdrf,
   output logic              idle,
   output logic              rx_irq,
   output logic              rwu
);

   generate
      if (OVS < 4) begin : g_bad_ovs
         $error("mdrx_rx: OVS must be at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mdrx_rx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              rx_s;
   logic              frm_start;
   logic              frm_done;
   logic [WORD_W-1:0] frm_word;
   fmt_e              frm_fmt;
   logic              idle_evt;
   fmt_e              fmt_sel;

   assign fmt_sel = fmt_e'(fmt);

   mdrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
   );

   mdrx_frame #(.OVS(OVS), .VOTE3(VOTE3)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s), .re(re),
      .fmt(fmt_sel), .start_ok(frm_start), .done(frm_done),
      .word(frm_word), .word_fmt(frm_fmt)
   );

   mdrx_idle #(.OVS(OVS)) u_idle (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s),
      .fmt(fmt_sel), .idle_evt(idle_evt)
   );

   mdrx_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .rwu_set(rwu_set), .rwu_clr(rwu_clr),
      .wake_sel(wake_sel), .sync_mode(sync_mode), .rx_ie(rx_ie),
      .rd_strobe(rd_strobe), .done(frm_done), .word(frm_word),
      .word_fmt(frm_fmt), .start_ok(frm_start), .idle_evt(idle_evt),
      .rx_data(rx_data), .rx_addr(rx_addr), .rdrf(rdrf), .idle(idle),
      .rx_irq(rx_irq), .rwu(rwu)
   );

endmodule

// File: rtl/mdrx_rx_chk.sv
module mdrx_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic rwu_set,
   input logic rwu_clr,
   input logic sync_mode,
   input logic rx_ie,
   input logic rd_strobe,
   input logic rdrf,
   input logic rx_irq,
   input logic rwu,
   input logic idle,
   input logic frm_done,
   input logic frm_start
);

   assert_sleep_hides_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rwu && !sync_mode) |-> (!rdrf && !rx_irq));

   assert_rwu_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rwu_set |=> rwu);

   assert_rwu_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rwu_clr && !rwu_set) |=> !rwu);

   assert_sync_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && rwu && !rwu_clr) |=> rwu);

   assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !frm_done) |=> !rdrf);

   assert_irq_needs_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ie |-> !rx_irq);

   assert_idle_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
      frm_start |=> !idle);

endmodule

bind mdrx_rx mdrx_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rwu_set(rwu_set), .rwu_clr(rwu_clr),
   .sync_mode(sync_mode), .rx_ie(rx_ie), .rd_strobe(rd_strobe),
   .rdrf(rdrf), .rx_irq(rx_irq), .rwu(rwu), .idle(idle),
   .frm_done(frm_done), .frm_start(frm_start)
);

// File: tb/mdrx_rx_bench.sv
module mdrx_rx_bench;

   localparam int OVS = 8;
   localparam int SYNC = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       rxd = 1'b1;
   logic       re = 1'b0;
   logic       rwu_set = 1'b0;
   logic       rwu_clr = 1'b0;
   logic       wake_sel = 1'b0;
   logic [1:0] fmt = 2'd0;
   logic       sync_mode = 1'b0;
   logic       rx_ie = 1'b0;
   logic       rd_strobe = 1'b0;
   logic [8:0] rx_data;
   logic       rx_addr, rdrf, idle, rx_irq, rwu;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   // behavioural expectation state
   bit m_rwu = 0, m_rdrf = 0, m_addr = 0;
   int m_data = 0;

   always #4 clk = ~clk;

   mdrx_rx #(.OVS(OVS), .SYNC_STAGES(SYNC), .VOTE3(1'b1)) u_mdrx_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .re(re),
      .rwu_set(rwu_set), .rwu_clr(rwu_clr), .wake_sel(wake_sel), .fmt(fmt),
      .sync_mode(sync_mode), .rx_ie(rx_ie), .rd_strobe(rd_strobe),
      .rx_data(rx_data), .rx_addr(rx_addr), .rdrf(rdrf), .idle(idle),
      .rx_irq(rx_irq), .rwu(rwu)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_set();  rwu_set = 1; wait_n(1); rwu_set = 0; wait_n(1); m_rwu = 1; endtask
   task automatic pulse_clr();  rwu_clr = 1; wait_n(1); rwu_clr = 0; wait_n(1); m_rwu = 0; endtask
   task automatic pulse_rd();   rd_strobe = 1; wait_n(1); rd_strobe = 0; wait_n(1); m_rdrf = 0; endtask

   // predicted outcome of one frame, from the requirements
   task automatic predict(input int f, input int w, input bit started);
      int  nb;
      bit  ab, sleeping;
      nb = (f == 1 || f == 2) ? 9 : 8;
      ab = (f == 2) ? w[8] : w[7];
      sleeping = m_rwu && !sync_mode;
      if (!started) return;
      if (sleeping && wake_sel && ab) m_rwu = 0;
      if (!sleeping || (wake_sel && ab)) begin
         m_rdrf = 1;
         m_addr = ab;
         m_data = (nb == 8) ? (w & 'hFF) : (w & 'h1FF);
      end
   endtask

   // drives one frame; drop_at >= 0 lowers re at that payload bit
   task automatic send(input int f, input int w, input int drop_at);
      int  nb;
      bit  started;
      nb = (f == 1 || f == 2) ? 9 : 8;
      started = re;
      rxd = 0; wait_n(OVS);
      for (int i = 0; i < nb; i++) begin
         if (i == drop_at) re = 0;
         rxd = w[i]; wait_n(OVS);
      end
      rxd = 1; wait_n(OVS);
      predict(f, w, started);
   endtask

   task automatic compare(input string tag);
      bit vis;
      vis = m_rdrf && !(m_rwu && !sync_mode);
      chk({tag, " rdrf"}, rdrf, vis);
      chk({tag, " irq R7"}, rx_irq, vis && rx_ie);
      chk({tag, " data"}, rx_data, m_data);
      chk({tag, " addr R3"}, rx_addr, m_addr);
      chk({tag, " rwu"}, rwu, m_rwu);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      wait_n(5);
      rst_n = 1;
      wait_n(2);
      chk("R11 reset rwu", rwu, 0);
      chk("R11 reset rdrf", rdrf, 0);
      chk("R11 reset idle", idle, 0);
      chk("R11 reset irq", rx_irq, 0);
      wait_n(100);
      chk("R13 no idle before traffic", idle, 0);

      re = 1; rx_ie = 1; fmt = 0;
      send(0, 'h0A5, -1); wait_n(5); compare("R2 R1 fmt0");
      pulse_rd(); compare("R4 read");

      fmt = 2;
      send(2, 'h13C, -1); wait_n(5); compare("R3 fmt2 hi"); pulse_rd();
      send(2, 'h0FF, -1); wait_n(5); compare("R3 fmt2 lo"); pulse_rd();
      fmt = 1;
      send(1, 'h17F, -1); wait_n(5); compare("R1 R3 fmt1"); pulse_rd();
      fmt = 0;
      send(0, 'h1C3, -1); wait_n(5); compare("R1 fmt0 bit8"); 
      chk("R1 bit8 zero", rx_data[8], 0); pulse_rd();

      send(0, 'h05A, 3); wait_n(5); compare("R5 drop midframe");
      send(0, 'h033, -1); wait_n(5); compare("R6 re low keeps rdrf");
      pulse_rd();
      send(0, 'h077, -1); wait_n(5); compare("R5 re low no load");
      re = 1;

      rxd = 0; wait_n(2); rxd = 1; wait_n(40); compare("R1 glitch");

      send(0, 'h011, -1); wait_n(5); compare("R2 before sleep");
      pulse_set(); compare("R8 R11 sleep hides");
      pulse_clr(); compare("R8 R11 flag back"); pulse_rd();

      wake_sel = 1; fmt = 2; pulse_set();
      send(2, 'h0AA, -1); wait_n(5); compare("R8 R9 no wake");
      send(2, 'h155, -1); wait_n(5); compare("R9 addr wake fmt2"); pulse_rd();
      fmt = 0; pulse_set();
      send(0, 'h07F, -1); wait_n(5); compare("R9 fmt0 no wake");
      send(0, 'h080, -1); wait_n(5); compare("R9 fmt0 wake"); pulse_rd();

      pulse_set();
      send(0, 'h02A, -1); wait_n(80 - 9);
      chk("R13 fmt0 before run", idle, 0);
      wait_n(10);
      chk("R13 fmt0 after run", idle, 1);
      chk("R8 asleep still", rwu, 1);
      pulse_clr();

      fmt = 1;
      send(1, 'h03C, -1); wait_n(88 - 9);
      chk("R13 fmt1 before run", idle, 0);
      wait_n(10);
      chk("R13 fmt1 after run", idle, 1);
      compare("R2 fmt1 load"); pulse_rd();

      fmt = 0; wake_sel = 0; pulse_set();
      send(0, 'h044, -1); wait_n(80 - 9);
      compare("R8 R10 asleep");
      wait_n(10); m_rwu = 0;
      compare("R10 idle wake");
      send(0, 'h066, -1); wait_n(5); compare("R10 next loaded");
      chk("R13 idle cleared", idle, 0); pulse_rd();

      sync_mode = 1; wake_sel = 1; pulse_set();
      send(0, 'h099, -1); wait_n(5); compare("R12 sync ignores rwu");
      pulse_rd(); pulse_clr(); sync_mode = 0;
      compare("R11 final");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule